// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block sits beside the execute stage of a five-stage in-order pipeline. It decides where each of the two ALU operands comes from: the value read from the register file in decode, or a result that is still in flight. An in-flight result may be in the execute/memory pipeline register, which holds the younger instruction, or in the memory/writeback pipeline register, which holds the older one. The inputs are the two source register numbers held in the decode/execute register, and the destination register number and write flag of each later stage. The outputs are two 2-bit select codes, one for each operand mux.

The selector is purely combinational. It has no clock and no reset. Every output follows the current inputs within the same cycle. Register 0 is wired to zero in the register file, so a write aimed at it never counts as a result to forward. When both later stages hold a result for the same register, the younger one is chosen. The operand muxes, the ALU, the register file and the stall logic are outside the block.

Top module: `fwd_unit`

## Requirements
- R1: Each select output uses this encoding: 2'b00 takes the register file value, 2'b10 takes the execute/memory result, and 2'b01 takes the memory/writeback result. The code 2'b11 is never produced.
- R2: `sel_a` is 2'b10 whenever `mem_wen` is 1, `mem_dst` is nonzero and `mem_dst` equals `src_a`.
- R3: `sel_b` is 2'b10 whenever `mem_wen` is 1, `mem_dst` is nonzero and `mem_dst` equals `src_b`.
- R4: An operand's select is 2'b01 when three things hold: `wb_wen` is 1, `wb_dst` is nonzero and equals that operand's source number, and the execute/memory condition for that operand is false.
- R5: When both stages match the same operand, the execute/memory result wins. In a chain of back-to-back writes to one register, the selected operand always equals the newest value produced.
- R6: A destination of register 0 never forwards, even with its write flag set. It also does not block a valid forward from the other stage.
- R7: A stage whose write flag is 0 never forwards, whatever its destination number.
- R8: Operands A and B are resolved independently. In one cycle each may select a different stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 5 | Source register number of operand A, from the decode/execute register |
| src_b | input | 5 | Source register number of operand B, from the decode/execute register |
| mem_dst | input | 5 | Destination register number in the execute/memory register |
| mem_wen | input | 1 | Register-write flag in the execute/memory register |
| wb_dst | input | 5 | Destination register number in the memory/writeback register |
| wb_wen | input | 1 | Register-write flag in the memory/writeback register |
| sel_a | output | 2 | Mux select for operand A (encoding in R1) |
| sel_b | output | 2 | Mux select for operand B (encoding in R1) |

## Verification
The bench targets the double hazard, where both stages hold a result for the same register. A selector with the priority reversed would feed the ALU a stale value, one update behind. It drives register-0 destinations with their write flags set. A design that skips the zero test would forward a nonzero result into a read of register 0. A design that lets a zero destination veto the other stage would lose a valid writeback forward. Cleared write flags paired with matching destinations catch a design that forwards on number alone. A modelled pipeline with operand muxes then replays dependent chains and compares each operand against a reference register state.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned OPERANDS = 2;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } src_sel_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] dst,
  input  logic             wen,
  input  logic [REG_W-1:0] src,
  output logic             hit
);
  // A stage carries a usable result only if it writes a real register.
  logic dst_live;
  assign dst_live = wen && (dst != '0);
  assign hit      = dst_live && (dst == src);
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
(
  input  logic       mem_hit,
  input  logic       wb_hit,
  output logic [1:0] sel
);
  src_sel_e choice;

  // The younger stage holds the newer value for the register, so it is checked first.
  always_comb begin
    if (mem_hit)     choice = SRC_MEM;
    else if (wb_hit) choice = SRC_WB;
    else             choice = SRC_RF;
  end

  assign sel = choice;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b
);
  logic [REG_W-1:0] src     [OPERANDS];
  logic [1:0]       sel     [OPERANDS];
  logic             mem_hit [OPERANDS];
  logic             wb_hit  [OPERANDS];

  assign src[0] = src_a;
  assign src[1] = src_b;

  for (genvar k = 0; k < OPERANDS; k++) begin : g_opnd
    fwd_hit #(.REG_W(REG_W)) u_mem_hit (
      .dst (mem_dst),
      .wen (mem_wen),
      .src (src[k]),
      .hit (mem_hit[k])
    );

    fwd_hit #(.REG_W(REG_W)) u_wb_hit (
      .dst (wb_dst),
      .wen (wb_wen),
      .src (src[k]),
      .hit (wb_hit[k])
    );

    fwd_pick u_pick (
      .mem_hit (mem_hit[k]),
      .wb_hit  (wb_hit[k]),
      .sel     (sel[k])
    );

    always_comb begin
      assert_no_code11_R1: assert (sel[k] != 2'b11);
      if (src[k] == '0) begin
        assert_zero_src_R6: assert (sel[k] == SRC_RF);
      end
      if (sel[k] == SRC_WB) begin
        assert_wb_valid_R4: assert (wb_wen && (wb_dst == src[k]) &&
                                    !(mem_wen && (mem_dst == src[k])));
      end
      if (sel[k] == SRC_MEM) begin
        assert_mem_valid_R7: assert (mem_wen && (mem_dst == src[k]));
      end
      if (mem_hit[k]) begin
        assert_mem_wins_R5: assert (sel[k] == SRC_MEM);
      end
    end
  end

  assign sel_a = sel[0];
  assign sel_b = sel[1];
endmodule

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
  logic       clk = 1'b0;
  logic [4:0] src_a, src_b, mem_dst, wb_dst;
  logic       mem_wen, wb_wen;
  logic [1:0] sel_a, sel_b;
  int         n_run  = 0;
  int         n_fail = 0;
  bit         done   = 0;

  always #10 clk = ~clk;

  fwd_unit u_fwd_unit (
    .src_a(src_a), .src_b(src_b), .mem_dst(mem_dst), .mem_wen(mem_wen),
    .wb_dst(wb_dst), .wb_wen(wb_wen), .sel_a(sel_a), .sel_b(sel_b)
  );

  // {src_a, src_b, mem_dst, mem_wen, wb_dst, wb_wen, exp_a, exp_b}
  localparam int NV = 13;
  localparam logic [25:0] VEC [NV] = '{
    {5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b00}, // R1 no match
    {5'd3,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b10, 2'b00}, // R2
    {5'd2,  5'd3,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b10}, // R3
    {5'd4,  5'd5,  5'd3,  1'b1, 5'd4,  1'b1, 2'b01, 2'b00}, // R4
    {5'd7,  5'd7,  5'd7,  1'b1, 5'd7,  1'b1, 2'b10, 2'b10}, // R5
    {5'd7,  5'd7,  5'd7,  1'b0, 5'd7,  1'b1, 2'b01, 2'b01}, // R7
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R6
    {5'd9,  5'd9,  5'd9,  1'b0, 5'd9,  1'b0, 2'b00, 2'b00}, // R7
    {5'd5,  5'd6,  5'd5,  1'b1, 5'd6,  1'b1, 2'b10, 2'b01}, // R8
    {5'd6,  5'd5,  5'd5,  1'b1, 5'd6,  1'b1, 2'b01, 2'b10}, // R8
    {5'd31, 5'd31, 5'd31, 1'b1, 5'd0,  1'b1, 2'b10, 2'b10}, // R2
    {5'd0,  5'd8,  5'd0,  1'b1, 5'd8,  1'b1, 2'b00, 2'b01}, // R6
    {5'd12, 5'd12, 5'd0,  1'b1, 5'd12, 1'b1, 2'b01, 2'b01}  // R6
  };
  localparam string VREQ [NV] = '{"R1","R2","R3","R4","R5","R7","R6",
                                  "R7","R8","R8","R2","R6","R6"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Pipeline model: dst, s1, s2, wen per instruction
  localparam int NI = 10;
  localparam logic [15:0] PROG [NI] = '{
    {5'd1, 5'd1, 5'd2, 1'b1},
    {5'd1, 5'd1, 5'd3, 1'b1},
    {5'd1, 5'd1, 5'd4, 1'b1},
    {5'd0, 5'd1, 5'd1, 1'b1},
    {5'd5, 5'd0, 5'd1, 1'b1},
    {5'd5, 5'd5, 5'd5, 1'b0},
    {5'd6, 5'd5, 5'd0, 1'b1},
    {5'd7, 5'd6, 5'd1, 1'b1},
    {5'd8, 5'd7, 5'd6, 1'b1},
    {5'd8, 5'd8, 5'd8, 1'b1}
  };

  initial begin
    logic [31:0] rf   [32];
    logic [31:0] arch [32];
    logic [31:0] m_val, w_val, opa, opb, res;
    logic [4:0]  m_d, w_d;
    logic        m_e, w_e;

    src_a = '0; src_b = '0; mem_dst = '0; wb_dst = '0; mem_wen = 0; wb_wen = 0;
    @(negedge clk);
    check("R1 idle", {30'd0, sel_a}, 32'd0);
    check("R1 idle", {30'd0, sel_b}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      {src_a, src_b, mem_dst, mem_wen, wb_dst, wb_wen} = VEC[i][25:4];
      @(negedge clk);
      check({VREQ[i], " sel_a"}, {30'd0, sel_a}, {30'd0, VEC[i][3:2]});
      check({VREQ[i], " sel_b"}, {30'd0, sel_b}, {30'd0, VEC[i][1:0]});
    end

    // Dependent chain (R5): operand must equal the newest architectural value
    for (int r = 0; r < 32; r++) begin
      rf[r] = (r == 0) ? 32'd0 : 32'h100 * r + 32'd1;
      arch[r] = rf[r];
    end
    m_val = '0; w_val = '0; m_d = '0; w_d = '0; m_e = 0; w_e = 0;
    for (int i = 0; i < NI; i++) begin
      @(posedge clk);
      src_a = PROG[i][10:6]; src_b = PROG[i][5:1];
      mem_dst = m_d; mem_wen = m_e; wb_dst = w_d; wb_wen = w_e;
      @(negedge clk);
      opa = (sel_a == 2'b10) ? m_val : (sel_a == 2'b01) ? w_val : rf[src_a];
      opb = (sel_b == 2'b10) ? m_val : (sel_b == 2'b01) ? w_val : rf[src_b];
      check("R5 chain operand A", opa, arch[src_a]);
      check("R5 chain operand B", opb, arch[src_b]);
      res = arch[src_a] + arch[src_b] + 32'd1;
      if (PROG[i][0] && PROG[i][15:11] != 5'd0) arch[PROG[i][15:11]] = res;
      if (w_e && w_d != 5'd0) rf[w_d] = w_val;
      w_val = m_val; w_d = m_d; w_e = m_e;
      m_val = res; m_d = PROG[i][15:11]; m_e = PROG[i][0];
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule